// File: doc/BRIEF.md
# Page Table Line Coalescing and Fill Steering

This block sits on the refill path of a two-level address translation cache. The miss path has two buffers: one holds clustered entries, where a single tag covers an aligned group of eight virtual pages, and the other holds ordinary single-page translations. When the page table walker returns the 64-byte line that holds the requested translation, the block receives it. That line carries eight 8-byte page table entries for the aligned group of eight virtual pages around the missed page.

The block picks out every entry that is present and whose physical page number, with its three least significant bits ignored, equals that of the requested entry. These entries form the group. Order inside the line and gaps between members do not matter. The block then counts the group and compares the count with a run-time threshold. If the count reaches the threshold, it issues one clustered fill: a shared virtual base, a shared physical base, a membership mask and eight 3-bit low fields. Otherwise it issues a single-page fill for the requested page only. If the requested entry itself is not present, the block issues no fill and raises a fault pulse instead.

Top module: `ptfill_coalesce`

## Requirements
- R1: During and straight after a synchronous reset, `clu_fill_vld`, `one_fill_vld` and `walk_fault` are low.
- R2: Entry k of the line occupies bits [64k+63:64k]. Its present flag is bit 0 and its physical page number is bits 51:12. Bit k of `clu_mask` is set exactly when entry k is present and its page number bits 39:3 equal those of the requested entry. The requested entry is selected by `req_vpn[2:0]`. All other bits of an entry have no effect.
- R3: Field k of `clu_low`, bits [3k+2:3k], holds page number bits 2:0 of entry k when that entry is a group member, and zero otherwise.
- R4: `grp_len` reports the number of set bits in the mask, from 0 to 8. It updates together with every fill or fault.
- R5: When the requested entry is present and `grp_len >= thr`, only `clu_fill_vld` pulses. With it come `clu_vbase = req_vpn` with bits 2:0 dropped, and `clu_pbase` = the requested page number bits 39:3. A threshold of 0 acts as 1.
- R6: When the requested entry is present and `grp_len < thr`, only `one_fill_vld` pulses, with `one_vpn = req_vpn` and `one_ppn` = the requested entry's page number. A threshold from 9 to 15 always selects this path.
- R7: When the requested entry is not present, only `walk_fault` pulses, and `grp_len` reads 0.
- R8: A line accepted with `line_vld` high at a clock edge yields exactly one of the three pulses at the next edge, lasting one cycle. A cycle without `line_vld` yields no pulse. Lines may arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_vld | input | 1 | Walker line valid for this cycle |
| line_data | input | 512 | Eight page table entries, entry k at bits [64k+63:64k] |
| req_vpn | input | VPN_W (36) | Virtual page number of the missed page |
| thr | input | 4 | Cluster length threshold, default use 2 |
| clu_fill_vld | output | 1 | Clustered fill pulse |
| clu_vbase | output | VPN_W-3 | Virtual page number of the group without bits 2:0 |
| clu_pbase | output | 37 | Shared physical page number bits 39:3 |
| clu_mask | output | 8 | Group membership per entry |
| clu_low | output | 24 | Page number bits 2:0 per member entry |
| one_fill_vld | output | 1 | Single-page fill pulse |
| one_vpn | output | VPN_W | Virtual page of the single-page fill |
| one_ppn | output | 40 | Physical page of the single-page fill |
| walk_fault | output | 1 | Requested entry not present |
| grp_len | output | 4 | Number of group members |

## Verification
A wrong group match shows up in the cycle after the line is accepted. It appears as a wrong `clu_mask` bit or low field, and it also moves `grp_len`, which can flip the fill between the two buffers. A wrong threshold comparison or a wrong fault decision shows in that same cycle as the wrong valid pulse. A stuck or doubled valid register shows one cycle later, as a pulse without a matching accepted line. The vectors cover holes, shuffled order, a present entry that matches but lies outside the group, and thresholds at 0, 1, 8, 9 and 15.

// File: rtl/ptfill_pkg.sv
package ptfill_pkg;

    localparam int N_ENT   = 8;
    localparam int IDX_W   = $clog2(N_ENT);
    localparam int PTE_W   = 64;
    localparam int LINE_W  = N_ENT * PTE_W;
    localparam int PPN_LSB = 12;
    localparam int PPN_W   = 40;
    localparam int PPN_HI_W = PPN_W - IDX_W;
    localparam int LEN_W   = IDX_W + 1;

    typedef struct packed {
        logic             present;
        logic [PPN_W-1:0] ppn;
    } pte_view_t;

    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_CLUSTER = 2'd1,
        FK_SINGLE  = 2'd2,
        FK_FAULT   = 2'd3
    } fill_kind_e;

    function automatic pte_view_t pte_unpack(input logic [PTE_W-1:0] raw);
        pte_view_t v;
        v.present = raw[0];
        v.ppn     = raw[PPN_LSB +: PPN_W];
        return v;
    endfunction

    function automatic logic [LEN_W-1:0] count_ones(input logic [N_ENT-1:0] m);
        logic [LEN_W-1:0] c;
        c = '0;
        for (int k = 0; k < N_ENT; k++) begin
            c = c + LEN_W'(m[k]);
        end
        return c;
    endfunction

endpackage

// File: rtl/ptfill_pte_split.sv
module ptfill_pte_split
    import ptfill_pkg::*;
(
    input  logic [LINE_W-1:0]           line_data,
    output pte_view_t [N_ENT-1:0]       ents
);

    logic [N_ENT-1:0] unused_fields;

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic [PTE_W-1:0] raw;
        assign raw     = line_data[k*PTE_W +: PTE_W];
        assign ents[k] = pte_unpack(raw);
        // attribute and reserved bits carry no meaning here
        assign unused_fields[k] = ^{raw[PTE_W-1:PPN_LSB+PPN_W], raw[PPN_LSB-1:1]};
    end

endmodule

// File: rtl/ptfill_group_match.sv
module ptfill_group_match
    import ptfill_pkg::*;
(
    input  pte_view_t [N_ENT-1:0]       ents,
    input  logic [IDX_W-1:0]            req_idx,
    output pte_view_t                   req_ent,
    output logic [N_ENT-1:0]            mask,
    output logic [N_ENT-1:0][IDX_W-1:0] lows
);

    logic [PPN_HI_W-1:0] req_hi;

    assign req_ent = ents[req_idx];
    assign req_hi  = req_ent.ppn[PPN_W-1:IDX_W];

    for (genvar k = 0; k < N_ENT; k++) begin : g_cmp
        logic same_hi;
        assign same_hi = (ents[k].ppn[PPN_W-1:IDX_W] == req_hi);
        assign mask[k] = req_ent.present && ents[k].present && same_hi;
        assign lows[k] = mask[k] ? ents[k].ppn[IDX_W-1:0] : '0;
    end

endmodule

// File: rtl/ptfill_fill_steer.sv
module ptfill_fill_steer
    import ptfill_pkg::*;
#(
    parameter int VPN_W = 36
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_vld,
    input  pte_view_t                   req_ent,
    input  logic [N_ENT-1:0]            mask,
    input  logic [N_ENT-1:0][IDX_W-1:0] lows,
    input  logic [VPN_W-1:0]            req_vpn,
    input  logic [LEN_W-1:0]            thr,
    output fill_kind_e                  kind_q,
    output logic [LEN_W-1:0]            len_q,
    output logic [N_ENT-1:0]            mask_q,
    output logic [N_ENT*IDX_W-1:0]      low_q,
    output logic [VPN_W-1:0]            vpn_q,
    output logic [PPN_W-1:0]            ppn_q
);

    logic [LEN_W-1:0]       len_d;
    fill_kind_e             kind_d;
    logic [N_ENT*IDX_W-1:0] low_d;

    assign len_d = count_ones(mask);

    always_comb begin
        if (!req_ent.present) begin
            kind_d = FK_FAULT;
        end else if (len_d >= thr) begin
            kind_d = FK_CLUSTER;
        end else begin
            kind_d = FK_SINGLE;
        end
    end

    for (genvar k = 0; k < N_ENT; k++) begin : g_pack
        assign low_d[k*IDX_W +: IDX_W] = lows[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= FK_NONE;
            len_q  <= '0;
            mask_q <= '0;
            low_q  <= '0;
            vpn_q  <= '0;
            ppn_q  <= '0;
        end else if (in_vld) begin
            kind_q <= kind_d;
            len_q  <= len_d;
            mask_q <= mask;
            low_q  <= low_d;
            vpn_q  <= req_vpn;
            ppn_q  <= req_ent.ppn;
        end else begin
            kind_q <= FK_NONE;
        end
    end

endmodule

// File: rtl/ptfill_coalesce.sv
module ptfill_coalesce
    import ptfill_pkg::*;
#(
    parameter int VPN_W = 36
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    line_vld,
    input  logic [LINE_W-1:0]       line_data,
    input  logic [VPN_W-1:0]        req_vpn,
    input  logic [LEN_W-1:0]        thr,
    output logic                    clu_fill_vld,
    output logic [VPN_W-IDX_W-1:0]  clu_vbase,
    output logic [PPN_HI_W-1:0]     clu_pbase,
    output logic [N_ENT-1:0]        clu_mask,
    output logic [N_ENT*IDX_W-1:0]  clu_low,
    output logic                    one_fill_vld,
    output logic [VPN_W-1:0]        one_vpn,
    output logic [PPN_W-1:0]        one_ppn,
    output logic                    walk_fault,
    output logic [LEN_W-1:0]        grp_len
);

    pte_view_t [N_ENT-1:0]       ents;
    pte_view_t                   req_ent;
    logic [N_ENT-1:0]            mask;
    logic [N_ENT-1:0][IDX_W-1:0] lows;
    fill_kind_e                  kind_q;
    logic [VPN_W-1:0]            vpn_q;
    logic [PPN_W-1:0]            ppn_q;

    ptfill_pte_split u_split (
        .line_data (line_data),
        .ents      (ents)
    );

    ptfill_group_match u_match (
        .ents    (ents),
        .req_idx (req_vpn[IDX_W-1:0]),
        .req_ent (req_ent),
        .mask    (mask),
        .lows    (lows)
    );

    ptfill_fill_steer #(.VPN_W(VPN_W)) u_steer (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (line_vld),
        .req_ent (req_ent),
        .mask    (mask),
        .lows    (lows),
        .req_vpn (req_vpn),
        .thr     (thr),
        .kind_q  (kind_q),
        .len_q   (grp_len),
        .mask_q  (clu_mask),
        .low_q   (clu_low),
        .vpn_q   (vpn_q),
        .ppn_q   (ppn_q)
    );

    assign clu_fill_vld = (kind_q == FK_CLUSTER);
    assign one_fill_vld = (kind_q == FK_SINGLE);
    assign walk_fault   = (kind_q == FK_FAULT);
    assign clu_vbase    = vpn_q[VPN_W-1:IDX_W];
    assign clu_pbase    = ppn_q[PPN_W-1:IDX_W];
    assign one_vpn      = vpn_q;
    assign one_ppn      = ppn_q;

endmodule

// File: rtl/ptfill_coalesce_chk.sv
module ptfill_coalesce_chk
    import ptfill_pkg::*;
#(
    parameter int VPN_W = 36
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   line_vld,
    input logic [VPN_W-1:0]       req_vpn,
    input logic [LEN_W-1:0]       thr,
    input logic                   clu_fill_vld,
    input logic [N_ENT-1:0]       clu_mask,
    input logic                   one_fill_vld,
    input logic                   walk_fault,
    input logic [LEN_W-1:0]       grp_len
);

    // R8
    one_pulse_per_line_chk: assert property (@(posedge clk) disable iff (rst)
        line_vld |=> $countones({clu_fill_vld, one_fill_vld, walk_fault}) == 1);

    // R8
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !line_vld |=> !(clu_fill_vld || one_fill_vld || walk_fault));

    // R4
    len_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (clu_fill_vld || one_fill_vld) |-> grp_len == LEN_W'($countones(clu_mask)));

    // R5
    cluster_meets_thr_chk: assert property (@(posedge clk) disable iff (rst)
        clu_fill_vld |-> (grp_len >= $past(thr)));

    // R6
    single_below_thr_chk: assert property (@(posedge clk) disable iff (rst)
        one_fill_vld |-> (grp_len < $past(thr)));

    // R2
    req_in_group_chk: assert property (@(posedge clk) disable iff (rst)
        clu_fill_vld |-> clu_mask[$past(req_vpn[IDX_W-1:0])]);

    // R7
    fault_empty_group_chk: assert property (@(posedge clk) disable iff (rst)
        walk_fault |-> (grp_len == '0 && clu_mask == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(clu_fill_vld || one_fill_vld || walk_fault));

endmodule

bind ptfill_coalesce ptfill_coalesce_chk #(.VPN_W(VPN_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .line_vld     (line_vld),
    .req_vpn      (req_vpn),
    .thr          (thr),
    .clu_fill_vld (clu_fill_vld),
    .clu_mask     (clu_mask),
    .one_fill_vld (one_fill_vld),
    .walk_fault   (walk_fault),
    .grp_len      (grp_len)
);

// File: tb/ptfill_coalesce_tb_top.sv
module ptfill_coalesce_tb_top;

    localparam int VW = 36;
    localparam int NV = 11;
    localparam logic [1:0] K_SINGLE = 2'd0;
    localparam logic [1:0] K_CLUSTER = 2'd1;
    localparam logic [1:0] K_FAULT = 2'd2;

    // codes: entry k page number = {hi32, codes[8k+7:8k]}
    typedef struct packed {
        logic [7:0]  pres;
        logic [2:0]  idx;
        logic [3:0]  thr;
        logic [63:0] codes;
        logic [1:0]  kind;
        logic [3:0]  len;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'hFF, 3'd3, 4'd2, 64'h1210_110D_0C0A_0908, K_CLUSTER, 4'd5},
        '{8'hFF, 3'd5, 4'd2, 64'h1210_110D_0C0A_0908, K_CLUSTER, 4'd3},
        '{8'hFF, 3'd2, 4'd2, 64'h4038_3028_2018_1008, K_SINGLE,  4'd1},
        '{8'hFF, 3'd0, 4'd8, 64'h2320_2527_2126_2422, K_CLUSTER, 4'd8},
        '{8'hFF, 3'd6, 4'd8, 64'h3020_2527_2126_2422, K_SINGLE,  4'd7},
        '{8'hAA, 3'd1, 4'd3, 64'h0F0E_0D0C_0B0A_0908, K_CLUSTER, 4'd4},
        '{8'hFE, 3'd0, 4'd2, 64'h2320_2527_2126_2422, K_FAULT,   4'd0},
        '{8'hFF, 3'd4, 4'd1, 64'h4038_3028_2018_1008, K_CLUSTER, 4'd1},
        '{8'hFF, 3'd7, 4'd0, 64'h4038_3028_2018_1008, K_CLUSTER, 4'd1},
        '{8'hFF, 3'd3, 4'd9, 64'h2320_2527_2126_2422, K_SINGLE,  4'd8},
        '{8'hFF, 3'd0, 4'd15, 64'h0F0E_0D0C_0B0A_0908, K_SINGLE, 4'd8}
    };

    logic           clk = 1'b0;
    logic           rst;
    logic           line_vld;
    logic [511:0]   line_data;
    logic [VW-1:0]  req_vpn;
    logic [3:0]     thr;
    logic           clu_fill_vld;
    logic [VW-4:0]  clu_vbase;
    logic [36:0]    clu_pbase;
    logic [7:0]     clu_mask;
    logic [23:0]    clu_low;
    logic           one_fill_vld;
    logic [VW-1:0]  one_vpn;
    logic [39:0]    one_ppn;
    logic           walk_fault;
    logic [3:0]     grp_len;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptfill_coalesce #(.VPN_W(VW)) dut_i (
        .clk(clk), .rst(rst), .line_vld(line_vld), .line_data(line_data),
        .req_vpn(req_vpn), .thr(thr),
        .clu_fill_vld(clu_fill_vld), .clu_vbase(clu_vbase), .clu_pbase(clu_pbase),
        .clu_mask(clu_mask), .clu_low(clu_low),
        .one_fill_vld(one_fill_vld), .one_vpn(one_vpn), .one_ppn(one_ppn),
        .walk_fault(walk_fault), .grp_len(grp_len)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] ppn_of(input vec_t v, input int k, input int tag);
        return {32'h00AB_CD00 + 32'(tag), v.codes[8*k +: 8]};
    endfunction

    // junk in attribute / reserved bits must not matter
    function automatic logic [511:0] mk_line(input vec_t v, input int tag);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) begin
            l[64*k +: 64] = {12'hC3A, ppn_of(v, k, tag), 11'h2D5, v.pres[k]};
        end
        return l;
    endfunction

    function automatic logic [VW-1:0] vpn_of(input vec_t v, input int tag);
        return {33'h1_2345_6780 + 33'(tag), v.idx};
    endfunction

    task automatic drive(input vec_t v, input int tag);
        line_vld  = 1'b1;
        line_data = mk_line(v, tag);
        req_vpn   = vpn_of(v, tag);
        thr       = v.thr;
    endtask

    task automatic expect_result(input vec_t v, input int tag);
        logic [7:0]  m;
        logic [23:0] lo;
        logic [39:0] rp;
        rp = ppn_of(v, int'(v.idx), tag);
        m  = '0;
        lo = '0;
        for (int k = 0; k < 8; k++) begin
            if (v.pres[v.idx] && v.pres[k] && ppn_of(v, k, tag)[39:3] == rp[39:3]) begin
                m[k] = 1'b1;
                lo[3*k +: 3] = ppn_of(v, k, tag)[2:0];
            end
        end
        check(clu_fill_vld == (v.kind == K_CLUSTER), "R5 cluster pulse",
              64'(clu_fill_vld), 64'(v.kind == K_CLUSTER));
        check(one_fill_vld == (v.kind == K_SINGLE), "R6 single pulse",
              64'(one_fill_vld), 64'(v.kind == K_SINGLE));
        check(walk_fault == (v.kind == K_FAULT), "R7 fault pulse",
              64'(walk_fault), 64'(v.kind == K_FAULT));
        check(grp_len == v.len, "R4 group length", 64'(grp_len), 64'(v.len));
        if (v.kind == K_CLUSTER) begin
            check(clu_mask == m, "R2 member mask", 64'(clu_mask), 64'(m));
            check(clu_low == lo, "R3 low fields", 64'(clu_low), 64'(lo));
            check(clu_vbase == vpn_of(v, tag)[VW-1:3], "R5 virtual base",
                  64'(clu_vbase), 64'(vpn_of(v, tag)[VW-1:3]));
            check(clu_pbase == rp[39:3], "R5 physical base",
                  64'(clu_pbase), 64'(rp[39:3]));
        end else if (v.kind == K_SINGLE) begin
            check(one_vpn == vpn_of(v, tag), "R6 single vpn",
                  64'(one_vpn), 64'(vpn_of(v, tag)));
            check(one_ppn == rp, "R6 single ppn", 64'(one_ppn), 64'(rp));
        end
    endtask

    task automatic expect_quiet(input string req);
        check(!clu_fill_vld && !one_fill_vld && !walk_fault, req,
              64'({clu_fill_vld, one_fill_vld, walk_fault}), 64'(0));
    endtask

    initial begin
        rst = 1'b1; line_vld = 1'b0; line_data = '0; req_vpn = '0; thr = 4'd2;
        repeat (3) @(negedge clk);
        expect_quiet("R1 reset outputs");
        rst = 1'b0;
        @(negedge clk);
        expect_quiet("R1 after reset");

        // table walk: accept, sample next cycle, then confirm single pulse
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], i);
            @(negedge clk);
            line_vld = 1'b0;
            expect_result(VECS[i], i);
            @(negedge clk);
            expect_quiet("R8 pulse lasts one cycle");
        end

        // back-to-back lines
        drive(VECS[0], 20);
        @(negedge clk);
        drive(VECS[2], 21);
        expect_result(VECS[0], 20);
        @(negedge clk);
        drive(VECS[6], 22);
        expect_result(VECS[2], 21);
        @(negedge clk);
        line_vld = 1'b0;
        expect_result(VECS[6], 22);
        @(negedge clk);
        expect_quiet("R8 idle after burst");

        // data changes without valid: no pulse
        line_data = mk_line(VECS[3], 30);
        req_vpn = vpn_of(VECS[3], 30);
        repeat (2) @(negedge clk);
        expect_quiet("R8 no valid no pulse");

        // reset while a line is offered
        drive(VECS[3], 31);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        line_vld = 1'b0;
        expect_quiet("R1 reset overrides line");
        @(negedge clk);
        expect_quiet("R1 quiet after reset pulse");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule